// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Park Controller

This block sits between the synthesized clock sources of a multi-output clock generator and its output buffers. For every output it decides, once per source-clock cycle, whether the clock passes through or is parked. It also decides how a parked output looks: held at a fixed level, or released to high impedance. Single-ended channels carry one leg. Differential channels carry a true leg and a complement leg, each with its own output-enable.

A global power-down request and a software run bit are the control inputs. When the run bit is low, every output marked stoppable is stopped. Outputs that are not marked keep running. Each output also has its own enable. Every control is brought through a two-stage synchronizer in that output's own clock domain before it acts. The gating state of a single-ended channel changes only on the source's falling edge. The state of a differential channel changes only on the source's rising edge, which is when the complement leg falls. As a result, neither parking nor resuming can produce a shortened phase.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `pwr_dn` is 1, every single-ended output is held low, starting at a falling edge of its source. With `pwr_dn` driven just after a source rising edge P0, the output still completes its high phase after P2 and is low from P3 onward.
- R2: While `pwr_dn` is 1, every differential output parks at a rising edge of its source, which is a falling edge of the complement leg. The park lands at the third rising edge after the request, within 4 source periods, and from then on the complement leg is not driven.
- R3: During power-down, an enabled differential output follows its bit in `df_pd_hiz`. With the bit at 0, `df_t` is driven to 1 and `df_c` is at high impedance. With the bit at 1, both legs are at high impedance (both `*_oe` are 0). Power-down takes priority over a software stop.
- R4: While `sw_run` is 0, every output whose stoppable flag is 1 is stopped, with the same edge rules as R1 and R2. Setting `sw_run` back to 1 resumes those outputs.
- R5: An enabled output whose stoppable flag is 0 keeps toggling whatever the value of `sw_run`, as long as `pwr_dn` is 0.
- R6: While a differential output is stopped by software, the single group bit `df_stop_hiz` picks the parked form: 0 gives true driven high with complement at high impedance, 1 gives both legs at high impedance.
- R7: An output whose enable bit is 0 is parked. A single-ended output is held low. A differential output has both legs at high impedance, regardless of `pwr_dn` or its mode bits.
- R8: Outputs change only at source-clock edges. A single-ended output and a differential true leg are stable through each source high phase and each source low phase, so no short pulse can appear.
- R9: On resume, with the release driven just after rising edge P0, the first single-ended high phase is the full source high phase starting at P3. The differential legs are driven again from P3, with the true leg high and the complement leg low.
- R10: While `rst_n` is 0, every single-ended output is low and both legs of every differential output are at high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_se | input | N_SE | Source clock of each single-ended channel |
| clk_df | input | N_DF | Source clock of each differential channel |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| pwr_dn | input | 1 | Global power-down request, active high |
| sw_run | input | 1 | Software run bit; 0 stops stoppable outputs |
| se_stoppable | input | N_SE | Per single-ended output: 1 = follows `sw_run` |
| df_stoppable | input | N_DF | Per differential output: 1 = follows `sw_run` |
| se_enable | input | N_SE | Per single-ended output enable |
| df_enable | input | N_DF | Per differential output enable |
| df_pd_hiz | input | N_DF | Power-down park mode per differential output (1 = both legs Hi-Z) |
| df_stop_hiz | input | 1 | Software-stop park mode for the differential group (1 = both legs Hi-Z) |
| se_out | output | N_SE | Gated single-ended clocks |
| df_t | output | N_DF | True leg value of each differential output |
| df_c | output | N_DF | Complement leg value of each differential output |
| df_t_oe | output | N_DF | True leg drive enable (0 = high impedance) |
| df_c_oe | output | N_DF | Complement leg drive enable (0 = high impedance) |

## Verification
A wrong gating state shows at the ports within one source phase. An output that is running when it should be parked breaks the expected level in the next high or low phase. A state register clocked on the wrong edge trims or stretches a phase, which the phase-stability sampling catches immediately. A wrong choice of park mode shows at once as a mismatch between the output-enables of the true and complement legs. A wrong synchronizer depth moves the park or resume edge by one cycle, so the bench samples both at the exact rising edge where the change must happen and at the edge just before it.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic en;
    logic pd;
    logic stop;
  } se_ctl_t;

  typedef struct packed {
    logic en;
    logic pd;
    logic stop;
    logic pd_hiz;
    logic stop_hiz;
  } df_ctl_t;
endpackage

// File: rtl/clkstop_rst_sync.sv
module clkstop_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] rs_q;
  logic [1:0] rs_nx;

  assign rs_nx = {rs_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rs_q <= '0;
    else         rs_q <= rs_nx;
  end

  assign rst_n_o = rs_q[1];
endmodule

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [STAGES-1:0][W-1:0] pipe_nx;

  always_comb begin
    pipe_nx[0] = d;
    for (int k = 1; k < STAGES; k++) pipe_nx[k] = pipe_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_nx;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/clkstop_se_chan.sv
module clkstop_se_chan
  import clkstop_pkg::*;
(
  input  logic    src_clk,
  input  logic    arst_n,
  input  se_ctl_t ctl,
  output logic    clk_out
);
  logic    lrst_n;
  se_ctl_t ctl_s;
  logic    run_q;
  logic    run_nx;

  clkstop_rst_sync u_rst (.clk(src_clk), .arst_n(arst_n), .rst_n_o(lrst_n));

  clkstop_sync #(.W($bits(se_ctl_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk(src_clk), .rst_n(lrst_n), .d(ctl), .q(ctl_s)
  );

  assign run_nx = ctl_s.en & ~ctl_s.pd & ~ctl_s.stop;

  // State moves only while the source is low: no phase is ever trimmed.
  always_ff @(negedge src_clk or negedge lrst_n) begin
    if (!lrst_n) run_q <= 1'b0;
    else         run_q <= run_nx;
  end

  assign clk_out = src_clk & run_q;
endmodule

// File: rtl/clkstop_df_chan.sv
module clkstop_df_chan
  import clkstop_pkg::*;
(
  input  logic    src_clk,
  input  logic    arst_n,
  input  df_ctl_t ctl,
  output logic    leg_t,
  output logic    leg_c,
  output logic    leg_t_oe,
  output logic    leg_c_oe
);
  logic    lrst_n;
  df_ctl_t ctl_s;
  logic    run_q, run_nx;
  logic    hiz_q, hiz_nx;

  clkstop_rst_sync u_rst (.clk(src_clk), .arst_n(arst_n), .rst_n_o(lrst_n));

  clkstop_sync #(.W($bits(df_ctl_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk(src_clk), .rst_n(lrst_n), .d(ctl), .q(ctl_s)
  );

  // Disable wins, then power-down mode, then software-stop mode.
  always_comb begin
    run_nx = ctl_s.en & ~ctl_s.pd & ~ctl_s.stop;
    if (!ctl_s.en)     hiz_nx = 1'b1;
    else if (ctl_s.pd) hiz_nx = ctl_s.pd_hiz;
    else               hiz_nx = ctl_s.stop_hiz;
  end

  // Rising source edge = complement falling: true leg is already going high.
  always_ff @(posedge src_clk or negedge lrst_n) begin
    if (!lrst_n) begin
      run_q <= 1'b0;
      hiz_q <= 1'b1;
    end else begin
      run_q <= run_nx;
      hiz_q <= hiz_nx;
    end
  end

  assign leg_t    = run_q ? src_clk  : 1'b1;
  assign leg_c    = run_q ? ~src_clk : 1'b0;
  assign leg_t_oe = run_q | ~hiz_q;
  assign leg_c_oe = run_q;
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned N_SE = 3,
  parameter int unsigned N_DF = 2
) (
  input  logic [N_SE-1:0] clk_se,
  input  logic [N_DF-1:0] clk_df,
  input  logic            rst_n,
  input  logic            pwr_dn,
  input  logic            sw_run,
  input  logic [N_SE-1:0] se_stoppable,
  input  logic [N_DF-1:0] df_stoppable,
  input  logic [N_SE-1:0] se_enable,
  input  logic [N_DF-1:0] df_enable,
  input  logic [N_DF-1:0] df_pd_hiz,
  input  logic            df_stop_hiz,
  output logic [N_SE-1:0] se_out,
  output logic [N_DF-1:0] df_t,
  output logic [N_DF-1:0] df_c,
  output logic [N_DF-1:0] df_t_oe,
  output logic [N_DF-1:0] df_c_oe
);
  for (genvar i = 0; i < N_SE; i++) begin : g_se
    se_ctl_t ctl;
    assign ctl.en   = se_enable[i];
    assign ctl.pd   = pwr_dn;
    assign ctl.stop = ~sw_run & se_stoppable[i];

    clkstop_se_chan u_ch (
      .src_clk(clk_se[i]), .arst_n(rst_n), .ctl(ctl), .clk_out(se_out[i])
    );
  end

  for (genvar j = 0; j < N_DF; j++) begin : g_df
    df_ctl_t ctl;
    assign ctl.en       = df_enable[j];
    assign ctl.pd       = pwr_dn;
    assign ctl.stop     = ~sw_run & df_stoppable[j];
    assign ctl.pd_hiz   = df_pd_hiz[j];
    assign ctl.stop_hiz = df_stop_hiz;

    clkstop_df_chan u_ch (
      .src_clk(clk_df[j]), .arst_n(rst_n), .ctl(ctl),
      .leg_t(df_t[j]), .leg_c(df_c[j]),
      .leg_t_oe(df_t_oe[j]), .leg_c_oe(df_c_oe[j])
    );
  end
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int unsigned N_SE = 3,
  parameter int unsigned N_DF = 2
) (
  input logic [N_SE-1:0] clk_se,
  input logic [N_DF-1:0] clk_df,
  input logic            rst_n,
  input logic            pwr_dn,
  input logic            sw_run,
  input logic [N_SE-1:0] se_stoppable,
  input logic [N_DF-1:0] df_stoppable,
  input logic [N_SE-1:0] se_enable,
  input logic [N_DF-1:0] df_enable,
  input logic [N_DF-1:0] df_pd_hiz,
  input logic [N_SE-1:0] se_out,
  input logic [N_DF-1:0] df_t,
  input logic [N_DF-1:0] df_c_oe,
  input logic [N_DF-1:0] df_t_oe
);
  localparam logic [2:0] SETTLED = 3'd6;

  function automatic logic [2:0] sat_inc(input logic [2:0] v);
    return (v == 3'd7) ? v : v + 3'd1;
  endfunction

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    logic [2:0] pd_c, stp_c, run_c;
    always_ff @(posedge clk_se[i] or negedge rst_n) begin
      if (!rst_n) begin
        pd_c <= '0; stp_c <= '0; run_c <= '0;
      end else begin
        pd_c  <= pwr_dn ? sat_inc(pd_c) : '0;
        stp_c <= (!sw_run && se_stoppable[i]) ? sat_inc(stp_c) : '0;
        run_c <= (se_enable[i] && !pwr_dn && !se_stoppable[i]) ? sat_inc(run_c) : '0;
      end
    end

    assert_se_pd_low_R1: assert property (@(negedge clk_se[i]) disable iff (!rst_n)
      pd_c >= SETTLED |-> !se_out[i]);
    assert_se_stop_low_R4: assert property (@(negedge clk_se[i]) disable iff (!rst_n)
      stp_c >= SETTLED |-> !se_out[i]);
    assert_se_free_run_R5: assert property (@(negedge clk_se[i]) disable iff (!rst_n)
      run_c >= SETTLED |-> se_out[i]);
  end

  for (genvar j = 0; j < N_DF; j++) begin : g_df
    logic [2:0] drv_c, hz_c, dis_c;
    always_ff @(posedge clk_df[j] or negedge rst_n) begin
      if (!rst_n) begin
        drv_c <= '0; hz_c <= '0; dis_c <= '0;
      end else begin
        drv_c <= (pwr_dn && df_enable[j] && !df_pd_hiz[j]) ? sat_inc(drv_c) : '0;
        hz_c  <= (pwr_dn && df_enable[j] &&  df_pd_hiz[j]) ? sat_inc(hz_c)  : '0;
        dis_c <= !df_enable[j] ? sat_inc(dis_c) : '0;
      end
    end

    assert_df_pd_parked_R2: assert property (@(negedge clk_df[j]) disable iff (!rst_n)
      drv_c >= SETTLED |-> (!df_c_oe[j] && df_t_oe[j] && df_t[j]));
    assert_df_pd_hiz_R3: assert property (@(negedge clk_df[j]) disable iff (!rst_n)
      hz_c >= SETTLED |-> (!df_c_oe[j] && !df_t_oe[j]));
    assert_df_disabled_R7: assert property (@(negedge clk_df[j]) disable iff (!rst_n)
      dis_c >= SETTLED |-> (!df_c_oe[j] && !df_t_oe[j]));
  end
endmodule

bind clkstop_ctrl clkstop_chk #(.N_SE(N_SE), .N_DF(N_DF)) u_chk (
  .clk_se(clk_se), .clk_df(clk_df), .rst_n(rst_n), .pwr_dn(pwr_dn),
  .sw_run(sw_run), .se_stoppable(se_stoppable), .df_stoppable(df_stoppable),
  .se_enable(se_enable), .df_enable(df_enable), .df_pd_hiz(df_pd_hiz),
  .se_out(se_out), .df_t(df_t), .df_c_oe(df_c_oe), .df_t_oe(df_t_oe)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_ctrl;
  localparam int N_SE = 3;
  localparam int N_DF = 2;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_dn, sw_run, df_stop_hiz;
  logic [N_SE-1:0] se_stp, se_en, se_out;
  logic [N_DF-1:0] df_stp, df_en, df_pd_hiz, df_t, df_c, df_t_oe, df_c_oe;
  int n_chk = 0;
  int n_err = 0;

  always #HALF clk = ~clk;

  clkstop_ctrl #(.N_SE(N_SE), .N_DF(N_DF)) u0 (
    .clk_se({N_SE{clk}}), .clk_df({N_DF{clk}}), .rst_n(rst_n),
    .pwr_dn(pwr_dn), .sw_run(sw_run), .se_stoppable(se_stp), .df_stoppable(df_stp),
    .se_enable(se_en), .df_enable(df_en), .df_pd_hiz(df_pd_hiz), .df_stop_hiz(df_stop_hiz),
    .se_out(se_out), .df_t(df_t), .df_c(df_c), .df_t_oe(df_t_oe), .df_c_oe(df_c_oe)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic se_on(int i);
    return se_en[i] && !pwr_dn && !(!sw_run && se_stp[i]);
  endfunction
  function automatic logic df_park(int j);
    return !df_en[j] || pwr_dn || (!sw_run && df_stp[j]);
  endfunction
  function automatic logic df_hiz(int j);
    return !df_en[j] || (pwr_dn ? df_pd_hiz[j] : df_stop_hiz);
  endfunction
  function automatic string se_tag(int i);
    if (!se_en[i]) return "R7";
    if (pwr_dn) return "R1";
    if (!sw_run && se_stp[i]) return "R4";
    return se_stp[i] ? "R9" : "R5";
  endfunction
  function automatic string df_tag(int j);
    if (!df_en[j]) return "R7";
    if (pwr_dn) return "R3";
    if (!sw_run && df_stp[j]) return "R6";
    return "R5";
  endfunction

  // Phase stability monitor: outputs never change inside a source phase.
  initial begin : mon_r8
    logic [N_SE-1:0] s0;
    logic [N_DF-1:0] t0;
    forever begin
      @(clk);
      #1;
      s0 = se_out; t0 = df_t;
      #(HALF - 2);
      if (rst_n === 1'b1) begin
        for (int i = 0; i < N_SE; i++) chk("R8", "se phase", se_out[i], s0[i]);
        for (int j = 0; j < N_DF; j++) chk("R8", "t phase", df_t[j], t0[j]);
      end
    end
  end

  task automatic drive_at_edge();
    @(posedge clk);
    #2;
  endtask

  task automatic check_all();
    @(posedge clk);
    #5;
    for (int i = 0; i < N_SE; i++) chk(se_tag(i), "se high phase", se_out[i], se_on(i));
    for (int j = 0; j < N_DF; j++) begin
      chk(df_tag(j), "t_oe", df_t_oe[j], !df_park(j) || !df_hiz(j));
      chk(df_tag(j), "c_oe", df_c_oe[j], !df_park(j));
      if (!df_park(j) || !df_hiz(j)) chk(df_tag(j), "t high phase", df_t[j], 1'b1);
      if (!df_park(j)) chk(df_tag(j), "c high phase", df_c[j], 1'b0);
    end
    #(2*HALF/2);
    for (int i = 0; i < N_SE; i++) chk("R8", "se low phase", se_out[i], 1'b0);
    for (int j = 0; j < N_DF; j++) begin
      if (!df_park(j)) begin
        chk("R8", "t low phase", df_t[j], 1'b0);
        chk("R8", "c low phase", df_c[j], 1'b1);
      end else if (!df_hiz(j)) begin
        chk(df_tag(j), "t parked low phase", df_t[j], 1'b1);
      end
    end
  endtask

  task automatic settle_and_check();
    repeat (5) @(posedge clk);
    check_all();
  endtask

  task automatic run_main();
    rst_n = 1'b0; pwr_dn = 1'b0; sw_run = 1'b1; df_stop_hiz = 1'b0;
    se_stp = '0; df_stp = '0; se_en = '1; df_en = '1; df_pd_hiz = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #5;
    for (int i = 0; i < N_SE; i++) chk("R10", "se in reset", se_out[i], 1'b0);
    for (int j = 0; j < N_DF; j++) begin
      chk("R10", "t_oe in reset", df_t_oe[j], 1'b0);
      chk("R10", "c_oe in reset", df_c_oe[j], 1'b0);
    end
    drive_at_edge();
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    check_all();

    // R1/R2 power-down edge timing, driven park mode
    drive_at_edge();
    pwr_dn = 1'b1;
    @(posedge clk); @(posedge clk); #5;
    chk("R1", "se still high after P2", se_out[0], 1'b1);
    chk("R2", "c_oe still on after P2", df_c_oe[0], 1'b1);
    @(posedge clk); #5;
    chk("R1", "se low after P3", se_out[0], 1'b0);
    chk("R2", "c_oe off at P3", df_c_oe[0], 1'b0);
    chk("R3", "t_oe driven park", df_t_oe[0], 1'b1);
    chk("R3", "t parked high", df_t[0], 1'b1);
    #(HALF);
    chk("R1", "se low phase parked", se_out[0], 1'b0);
    chk("R2", "t stays high low phase", df_t[0], 1'b1);

    // R3 both legs high impedance
    drive_at_edge();
    df_pd_hiz = '1;
    settle_and_check();
    chk("R3", "t_oe hiz park", df_t_oe[1], 1'b0);

    // R9 resume timing
    drive_at_edge();
    pwr_dn = 1'b0;
    @(posedge clk); @(posedge clk); #5;
    chk("R9", "se not early", se_out[1], 1'b0);
    chk("R9", "t_oe not early", df_t_oe[1], 1'b0);
    @(posedge clk); #5;
    chk("R9", "se full high at P3", se_out[1], 1'b1);
    chk("R9", "c_oe back at P3", df_c_oe[1], 1'b1);
    chk("R9", "c low at P3", df_c[1], 1'b0);
    #(HALF);
    chk("R9", "se falls with source", se_out[1], 1'b0);
    chk("R9", "c high low phase", df_c[1], 1'b1);

    // R4/R5/R6 software stop in both group modes
    drive_at_edge();
    se_stp = 3'b101; df_stp = 2'b01; sw_run = 1'b0; df_stop_hiz = 1'b0;
    settle_and_check();
    chk("R5", "unstoppable se runs", se_out[1], 1'b0);
    drive_at_edge();
    df_stop_hiz = 1'b1;
    settle_and_check();
    drive_at_edge();
    sw_run = 1'b1;
    settle_and_check();

    // R7 disable overrides power-down driven mode
    drive_at_edge();
    pwr_dn = 1'b1; df_pd_hiz = '0; df_en = 2'b10; se_en = 3'b011;
    settle_and_check();
    drive_at_edge();
    pwr_dn = 1'b0;
    settle_and_check();

    // Random mix
    for (int n = 0; n < 60; n++) begin
      drive_at_edge();
      pwr_dn      = ($urandom % 5) == 0;
      sw_run      = $urandom % 2;
      df_stop_hiz = $urandom % 2;
      se_stp      = $urandom;
      df_stp      = $urandom;
      df_pd_hiz   = $urandom;
      for (int i = 0; i < N_SE; i++) se_en[i] = ($urandom % 4) != 0;
      for (int j = 0; j < N_DF; j++) df_en[j] = ($urandom % 4) != 0;
      settle_and_check();
    end
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule